// File: doc/BRIEF.md
# Parallel Display Bus Cycle Timer

This block drives the strobes of an asynchronous 8080-style parallel display bus, one access at a time. An access is a command write, a data (parameter) write or a bus read. The requester presents the kind and the write value with a valid flag. The block then plays out one bus cycle on the chip-select, write-strobe, read-strobe and address/command (A0) pins. Every edge of that cycle falls on a programmed tick count. The edge times come from two packed timing words. The block repairs any settings that break the ordering rules before it uses them. A granularity input makes each tick two clocks long instead of one, for slow panels.

For a read, the value on the incoming data bus is captured at a programmed access tick. It is then held on the read-data output until the next read. A busy flag covers the whole access and a one-clock done pulse marks its end. Requests are therefore serialized by the requester holding its valid flag until the block accepts it. The timing words, the granularity and the kind are sampled when a request is accepted. They may change freely while an access is running.

Top module: `dbt_cycle_timer`

## Requirements
- R1: The timing fields are decoded at fixed bit positions. In `onoff_word`, the chip-select on time is in [3:0] and its off time in [9:4]. The write-strobe on time is in [13:10] and its off time in [19:14]. The read-strobe on time is in [23:20] and its off time in [29:24]. In `cyc_word`, the write cycle length is in [5:0], the read cycle length is in [11:6] and the read access time is in [27:22]. Bits [21:12] of `cyc_word` have no effect.
- R2: Out-of-order settings are repaired before use. Each off time below its on time plus one is raised to that on time plus one. The chip-select off time is also raised to the larger of the two strobe off times. An access time below the read on time plus one is raised to that value. A cycle length below its strobe's repaired off time is raised to that off time. A write lasts until tick max(write cycle, CS off). A read lasts until tick max(read cycle, CS off, access time).
- R3: Tick t runs from 0 at acceptance. With `tick_x2` low each tick is one clock; with it high each tick is two clocks. An access that ends at tick E therefore keeps `busy` high for (E+1) or 2(E+1) clocks.
- R4: Chip-select is asserted while the tick count t satisfies CS-on ≤ t < CS-off. Pins show the state of the previous clock: a registered one-clock lag after acceptance.
- R5: The write strobe is asserted only in writes, while WE-on ≤ t < WE-off. The read strobe is asserted only in reads, while RE-on ≤ t < RE-off. The two are never asserted together.
- R6: `req_kind` code 0 is a command write, code 1 a data write, and codes 2 and 3 a read. A0 is asserted (command state) for a command write and negated for data writes and reads. A0 keeps its last value between accesses. During a write, `bus_oe` is high and `bus_dout` carries the accepted write value. During a read, `bus_oe` is low.
- R7: The bits of `pin_pol` are assigned as follows: bit 0 is A0, bit 1 the read strobe, bit 2 the write strobe and bit 3 chip-select. With a bit clear, the pin is driven low when asserted and high otherwise. With the bit set, these levels are swapped.
- R8: `busy` is high from the clock after acceptance until the access ends. `done` is high for exactly the one clock in which `busy` has just fallen.
- R9: A request presented while `busy` is high is not accepted. If it is withdrawn before `busy` falls, it leaves `bus_dout`, A0 and `busy` untouched.
- R10: In a read, `rd_data` takes the value of `bus_din` at the clock edge that ends tick number equal to the access time. It holds that value through later writes until the next read.
- R11: While reset is held, every strobe and A0 is negated (each pin at the inverse of its `pin_pol` bit). `busy`, `done`, `bus_oe` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| onoff_word | input | 30 | Packed on/off edge times |
| cyc_word | input | 28 | Packed cycle lengths and access time |
| tick_x2 | input | 1 | Tick lasts two clocks when high |
| pin_pol | input | 4 | Pin polarity select (A0, RE, WE, CS) |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 command, 1 data write, 2/3 read |
| req_wdata | input | DATA_W | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock end-of-access pulse |
| rd_data | output | DATA_W | Last captured read value |
| cs_o | output | 1 | Chip-select pin |
| we_o | output | 1 | Write-strobe pin |
| re_o | output | 1 | Read-strobe pin |
| a0_o | output | 1 | Address/command pin |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | DATA_W | Data bus output value |
| bus_din | input | DATA_W | Data bus input value |

## Verification
The bench plays every access kind at both tick lengths over a set of timing words. Some words are already legal and some need each repair rule. Others hold all-zero and all-maximum fields, and a generated series fills the ignored cycle-word bits with noise. Comparing every pin on every clock against an arithmetic model separates wrong field decoding and wrong clamping from off-by-one window edges and tick stretching. The polarity select walks through all sixteen values, so a swapped pin bit shows up. The input bus changes every clock, so a capture one clock early or late returns a different value. A request injected during a busy write shows whether requests are held off.

// File: rtl/dbt_pkg.sv
// Shared widths, field positions, request kinds and the repaired timing
// record of the display bus cycle timer. Assumes on-times are narrower
// than tick counts.
package dbt_pkg;
    parameter int unsigned TICK_W = 6;
    parameter int unsigned ON_W   = 4;

    localparam int unsigned ONOFF_W = 3 * ON_W + 3 * TICK_W;
    localparam int unsigned CYC_W   = 4 * TICK_W + ON_W;

    localparam int unsigned CS_ON_LSB  = 0;
    localparam int unsigned CS_OFF_LSB = ON_W;
    localparam int unsigned WE_ON_LSB  = ON_W + TICK_W;
    localparam int unsigned WE_OFF_LSB = 2 * ON_W + TICK_W;
    localparam int unsigned RE_ON_LSB  = 2 * ON_W + 2 * TICK_W;
    localparam int unsigned RE_OFF_LSB = 3 * ON_W + 2 * TICK_W;

    localparam int unsigned WCYC_LSB = 0;
    localparam int unsigned RCYC_LSB = TICK_W;
    localparam int unsigned SPARE_LSB = 2 * TICK_W;
    localparam int unsigned ACC_LSB  = 3 * TICK_W + ON_W;

    typedef logic [TICK_W-1:0] tick_t;

    typedef enum logic [1:0] {
        K_CMD   = 2'd0,
        K_PARAM = 2'd1,
        K_READ  = 2'd2
    } kind_e;

    typedef struct packed {
        tick_t cs_on;
        tick_t cs_off;
        tick_t we_on;
        tick_t we_off;
        tick_t re_on;
        tick_t re_off;
        tick_t acc;
        tick_t end_wr;
        tick_t end_rd;
    } timing_t;

    function automatic tick_t tmax(input tick_t a, input tick_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/dbt_timing_clamp.sv
// Decodes the two packed timing words and repairs illegal orderings.
// Purely combinational; the caller snapshots the result.
module dbt_timing_clamp
    import dbt_pkg::*;
(
    input  logic [ONOFF_W-1:0] onoff_word,
    input  logic [CYC_W-1:0]   cyc_word,
    output timing_t            tim
);
    localparam int unsigned PAD_W = TICK_W - ON_W;

    tick_t cs_on, cs_off_r, we_on, we_off_r, re_on, re_off_r;
    tick_t wcyc_r, rcyc_r, acc_r;
    tick_t we_off, re_off, cs_off, acc, wcyc, rcyc;
    logic  unused_spare;

    // Field extraction; on-times are zero-extended to tick width.
    always_comb begin
        cs_on    = {{PAD_W{1'b0}}, onoff_word[CS_ON_LSB +: ON_W]};
        cs_off_r = onoff_word[CS_OFF_LSB +: TICK_W];
        we_on    = {{PAD_W{1'b0}}, onoff_word[WE_ON_LSB +: ON_W]};
        we_off_r = onoff_word[WE_OFF_LSB +: TICK_W];
        re_on    = {{PAD_W{1'b0}}, onoff_word[RE_ON_LSB +: ON_W]};
        re_off_r = onoff_word[RE_OFF_LSB +: TICK_W];
        wcyc_r   = cyc_word[WCYC_LSB +: TICK_W];
        rcyc_r   = cyc_word[RCYC_LSB +: TICK_W];
        acc_r    = cyc_word[ACC_LSB +: TICK_W];
    end

    assign unused_spare = ^cyc_word[SPARE_LSB +: TICK_W + ON_W];

    // Ordering repair: raise each value to its nearest legal setting.
    always_comb begin
        we_off = tmax(we_off_r, we_on + 1'b1);
        re_off = tmax(re_off_r, re_on + 1'b1);
        cs_off = tmax(tmax(cs_off_r, cs_on + 1'b1), tmax(we_off, re_off));
        acc    = tmax(acc_r, re_on + 1'b1);
        wcyc   = tmax(wcyc_r, we_off);
        rcyc   = tmax(rcyc_r, re_off);
        tim.cs_on  = cs_on;
        tim.cs_off = cs_off;
        tim.we_on  = we_on;
        tim.we_off = we_off;
        tim.re_on  = re_on;
        tim.re_off = re_off;
        tim.acc    = acc;
        tim.end_wr = tmax(wcyc, cs_off);
        tim.end_rd = tmax(tmax(rcyc, cs_off), acc);
    end
endmodule

// File: rtl/dbt_tick_gen.sv
// Tick enable: every clock, or every second clock when stretched.
// Assumes start restarts the phase so the first tick is a full one.
module dbt_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic x2,
    output logic tick
);
    logic phase_q;

    // Phase toggles while running; cleared at the start of each access.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= 1'b0;
        else if (start)  phase_q <= 1'b0;
        else if (run)    phase_q <= ~phase_q;
    end

    assign tick = run & (~x2 | phase_q);
endmodule

// File: rtl/dbt_access_seq.sv
// Accepts one request when idle, snapshots its settings, counts ticks
// up to the end tick, pulses done and captures read data at the access
// tick. Assumes the requester holds req_valid until accepted.
module dbt_access_seq
    import dbt_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    input  timing_t           tim_in,
    input  logic              x2_in,
    input  logic [DATA_W-1:0] bus_din,
    output logic              active,
    output kind_e             kind_q,
    output tick_t             t_q,
    output timing_t           tim_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    typedef enum logic {S_IDLE, S_ACT} state_e;

    state_e state_q;
    logic   x2_q;
    logic   tick;
    logic   accept;
    logic   at_end;
    kind_e  kind_in;
    tick_t  end_sel;

    assign accept  = (state_q == S_IDLE) && req_valid;
    assign kind_in = req_kind[1] ? K_READ : (req_kind[0] ? K_PARAM : K_CMD);
    assign end_sel = (kind_q == K_READ) ? tim_q.end_rd : tim_q.end_wr;
    assign at_end  = (state_q == S_ACT) && tick && (t_q == end_sel);
    assign active  = (state_q == S_ACT);

    dbt_tick_gen tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .run   (state_q == S_ACT),
        .x2    (x2_q),
        .tick  (tick)
    );

    // Access state and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            t_q     <= '0;
        end else if (accept) begin
            state_q <= S_ACT;
            t_q     <= '0;
        end else if (at_end) begin
            state_q <= S_IDLE;
        end else if ((state_q == S_ACT) && tick) begin
            t_q <= t_q + 1'b1;
        end
    end

    // Request snapshot taken at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_PARAM;
            tim_q   <= '0;
            wdata_q <= '0;
            x2_q    <= 1'b0;
        end else if (accept) begin
            kind_q  <= kind_in;
            tim_q   <= tim_in;
            wdata_q <= req_wdata;
            x2_q    <= x2_in;
        end
    end

    // End-of-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= at_end;
    end

    // Read capture on the last clock of the access tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if ((state_q == S_ACT) && tick && (kind_q == K_READ) && (t_q == tim_q.acc))
            rd_data <= bus_din;
    end
endmodule

// File: rtl/dbt_pin_drive.sv
// Forms the asserted state of each pin from the tick count and the
// snapshot, registers it, and applies per-pin polarity after the flop.
// Pin index order: 0 A0, 1 read strobe, 2 write strobe, 3 chip-select.
module dbt_pin_drive
    import dbt_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  kind_e             kind,
    input  tick_t             t,
    input  timing_t           tim,
    input  logic [DATA_W-1:0] wdata,
    input  logic [3:0]        pin_pol,
    output logic [3:0]        pins,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout
);
    localparam int unsigned NPIN = 4;

    logic [NPIN-1:0] asrt_d, asrt_q;
    logic            is_rd;

    function automatic logic in_win(input tick_t tv, input tick_t on, input tick_t off);
        return (tv >= on) && (tv < off);
    endfunction

    assign is_rd = (kind == K_READ);

    // Asserted state of each pin for the current tick.
    always_comb begin
        asrt_d[0] = (kind == K_CMD);
        asrt_d[1] = active && is_rd  && in_win(t, tim.re_on, tim.re_off);
        asrt_d[2] = active && !is_rd && in_win(t, tim.we_on, tim.we_off);
        asrt_d[3] = active && in_win(t, tim.cs_on, tim.cs_off);
    end

    // Output registers for glitch-free pins and data bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asrt_q   <= '0;
            bus_oe   <= 1'b0;
            bus_dout <= '0;
        end else begin
            asrt_q   <= asrt_d;
            bus_oe   <= active && !is_rd;
            bus_dout <= wdata;
        end
    end

    // Polarity: a clear select bit means asserted drives low.
    for (genvar i = 0; i < NPIN; i++) begin : g_pol
        assign pins[i] = asrt_q[i] ^ ~pin_pol[i];
    end
endmodule

// File: rtl/dbt_cycle_timer.sv
// Top of the display bus cycle timer: timing repair, access sequencer
// and pin drivers. Assumes one access at a time, held-valid requests.
module dbt_cycle_timer
    import dbt_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ONOFF_W-1:0] onoff_word,
    input  logic [CYC_W-1:0]  cyc_word,
    input  logic              tick_x2,
    input  logic [3:0]        pin_pol,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              cs_o,
    output logic              we_o,
    output logic              re_o,
    output logic              a0_o,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din
);
    timing_t           tim_c, tim_q;
    logic              active;
    kind_e             kind_q;
    tick_t             t_q;
    logic [DATA_W-1:0] wdata_q;
    logic [3:0]        pins;

    dbt_timing_clamp clamp_i (
        .onoff_word (onoff_word),
        .cyc_word   (cyc_word),
        .tim        (tim_c)
    );

    dbt_access_seq #(.DATA_W(DATA_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .tim_in    (tim_c),
        .x2_in     (tick_x2),
        .bus_din   (bus_din),
        .active    (active),
        .kind_q    (kind_q),
        .t_q       (t_q),
        .tim_q     (tim_q),
        .wdata_q   (wdata_q),
        .done      (done),
        .rd_data   (rd_data)
    );

    dbt_pin_drive #(.DATA_W(DATA_W)) pins_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .kind     (kind_q),
        .t        (t_q),
        .tim      (tim_q),
        .wdata    (wdata_q),
        .pin_pol  (pin_pol),
        .pins     (pins),
        .bus_oe   (bus_oe),
        .bus_dout (bus_dout)
    );

    assign busy = active;
    assign a0_o = pins[0];
    assign re_o = pins[1];
    assign we_o = pins[2];
    assign cs_o = pins[3];
endmodule

// File: rtl/dbt_cycle_timer_chk.sv
// Protocol checker for the display bus cycle timer, bound to the top.
module dbt_cycle_timer_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        pin_pol,
    input logic              we_o,
    input logic              re_o,
    input logic              bus_oe,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd_data
);
    logic we_asrt, re_asrt;
    assign we_asrt = (we_o == pin_pol[2]);
    assign re_asrt = (re_o == pin_pol[1]);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_asrt && re_asrt)); // R5

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        re_asrt |-> !bus_oe); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

    AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_asrt || re_asrt) |-> $past(busy)); // R4

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data)); // R10
endmodule

bind dbt_cycle_timer dbt_cycle_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_pol (pin_pol),
    .we_o    (we_o),
    .re_o    (re_o),
    .bus_oe  (bus_oe),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/dbt_cycle_timer_tb_top.sv
// Bench: sweeps timing words, kinds, tick lengths and polarities, and
// compares every pin on every clock against an arithmetic model.
module dbt_cycle_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [29:0]   onoff_word = '0;
    logic [27:0]   cyc_word = '0;
    logic          tick_x2 = 1'b0;
    logic [3:0]    pin_pol = 4'b0101;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] bus_din = '0;
    logic          busy, done, cs_o, we_o, re_o, a0_o, bus_oe;
    logic [DW-1:0] rd_data, bus_dout;

    int errors = 0;
    int checks = 0;
    int acc_idx = 0;
    logic [DW-1:0] rd_model = '0;

    dbt_cycle_timer #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .onoff_word(onoff_word), .cyc_word(cyc_word),
        .tick_x2(tick_x2), .pin_pol(pin_pol), .req_valid(req_valid),
        .req_kind(req_kind), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .cs_o(cs_o), .we_o(we_o), .re_o(re_o), .a0_o(a0_o),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s acc=%0d actual=%0h expected=%0h", req, acc_idx, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Timing sets: five hand-picked ones, then a generated series.
    task automatic get_set(input int s, output logic [29:0] oo, output logic [27:0] cy);
        int cson, csoff, weon, weoff, reon, reoff, wcyc, rcyc, acc, spare;
        case (s)
            0: begin cson=1; csoff=8; weon=2; weoff=5; reon=2; reoff=6; wcyc=9; rcyc=10; acc=4; spare=0; end
            1: begin cson=3; csoff=2; weon=3; weoff=3; reon=5; reoff=2; wcyc=0; rcyc=0; acc=1; spare=0; end
            2: begin cson=0; csoff=0; weon=0; weoff=0; reon=0; reoff=0; wcyc=0; rcyc=0; acc=0; spare=0; end
            3: begin cson=15; csoff=63; weon=15; weoff=63; reon=15; reoff=63; wcyc=63; rcyc=63; acc=63; spare=1023; end
            4: begin cson=0; csoff=20; weon=1; weoff=4; reon=2; reoff=7; wcyc=10; rcyc=12; acc=30; spare=0; end
            default: begin
                cson=(s*5+1)%16; csoff=(s*13+3)%64; weon=(s*7+2)%16; weoff=(s*11+5)%64;
                reon=(s*3+4)%16; reoff=(s*17+1)%64; wcyc=(s*19+7)%64; rcyc=(s*23+2)%64;
                acc=(s*29+3)%64; spare=(s*97+13)%1024;
            end
        endcase
        oo = {reoff[5:0], reon[3:0], weoff[5:0], weon[3:0], csoff[5:0], cson[3:0]};
        cy = {acc[5:0], spare[9:0], rcyc[5:0], wcyc[5:0]};
    endtask

    task automatic run_access(input logic [1:0] kind, input logic [DW-1:0] data,
                              input logic [29:0] oo, input logic [27:0] cy,
                              input bit g, input logic [3:0] pol, input bit intrude);
        int cson, csoff, weon, weoff, reon, reoff, wcyc, rcyc, acc, endv, len, ncap, tp;
        bit isrd, e_cs, e_we, e_re, e_oe;
        logic [DW-1:0] cap;
        cson = oo[3:0]; csoff = oo[9:4]; weon = oo[13:10]; weoff = oo[19:14];
        reon = oo[23:20]; reoff = oo[29:24];
        wcyc = cy[5:0]; rcyc = cy[11:6]; acc = cy[27:22];
        weoff = imax(weoff, weon + 1);
        reoff = imax(reoff, reon + 1);
        csoff = imax(imax(csoff, cson + 1), imax(weoff, reoff));
        acc   = imax(acc, reon + 1);
        wcyc  = imax(wcyc, weoff);
        rcyc  = imax(rcyc, reoff);
        isrd  = kind[1];
        endv  = isrd ? imax(imax(rcyc, csoff), acc) : imax(wcyc, csoff);
        len   = (endv + 1) * (g ? 2 : 1);
        ncap  = (acc + 1) * (g ? 2 : 1) - 1;
        cap   = rd_model;
        @(negedge clk);
        onoff_word = oo; cyc_word = cy; tick_x2 = g; pin_pol = pol;
        req_kind = kind; req_wdata = data; req_valid = 1'b1;
        @(posedge clk);
        for (int n = 0; n <= len + 1; n++) begin
            @(negedge clk);
            if (n == 0) begin
                req_valid = 1'b0;
                onoff_word = ~oo; cyc_word = ~cy; tick_x2 = ~g;
            end
            if (intrude && n == 1) begin req_valid = 1'b1; req_kind = 2'd0; req_wdata = ~data; end
            if (intrude && n == len - 1) req_valid = 1'b0;
            bus_din = 16'h3C00 + 16'(acc_idx * 7) + 16'(n * 37);
            if (n == ncap) cap = bus_din;
            tp = (n >= 1) ? (n - 1) / (g ? 2 : 1) : 0;
            e_cs = (n >= 1) && (n <= len) && (tp >= cson) && (tp < csoff);
            e_we = !isrd && (n >= 1) && (n <= len) && (tp >= weon) && (tp < weoff);
            e_re = isrd && (n >= 1) && (n <= len) && (tp >= reon) && (tp < reoff);
            e_oe = !isrd && (n >= 1) && (n <= len);
            chk(busy == (n < len), "R3 R8 busy", busy, n < len);
            chk(done == (n == len), "R8 done", done, n == len);
            chk(cs_o == (e_cs ? pol[3] : ~pol[3]), "R4 R1 R2 R7 cs", cs_o, e_cs ? pol[3] : ~pol[3]);
            chk(we_o == (e_we ? pol[2] : ~pol[2]), "R5 R1 R2 R7 we", we_o, e_we ? pol[2] : ~pol[2]);
            chk(re_o == (e_re ? pol[1] : ~pol[1]), "R5 R1 R2 R7 re", re_o, e_re ? pol[1] : ~pol[1]);
            chk(bus_oe == e_oe, "R6 oe", bus_oe, e_oe);
            if (n >= 1) begin
                chk(a0_o == ((kind == 2'd0) ? pol[0] : ~pol[0]), "R6 R7 a0", a0_o,
                    (kind == 2'd0) ? pol[0] : ~pol[0]);
                if (!isrd) chk(bus_dout == data, "R6 R9 dout", bus_dout, data);
            end
            if (n == len) begin
                if (isrd) chk(rd_data == cap, "R10 capture", rd_data, cap);
                else      chk(rd_data == rd_model, "R10 hold", rd_data, rd_model);
            end
        end
        if (isrd) rd_model = cap;
        if (intrude) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b0, "R9 not accepted", busy, 0);
            chk(bus_dout == data, "R9 dout kept", bus_dout, data);
        end
        acc_idx++;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [29:0] oo;
        logic [27:0] cy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cs_o == 1'b1 && we_o == 1'b0 && re_o == 1'b1 && a0_o == 1'b0, "R11 pins",
            {cs_o, we_o, re_o, a0_o}, 4'b1010);
        chk(busy == 0 && done == 0 && bus_oe == 0, "R11 flags", {busy, done, bus_oe}, 0);
        chk(rd_data == '0, "R11 rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int s = 0; s < 29; s++) begin
            get_set(s, oo, cy);
            for (int g = 0; g < 2; g++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [1:0] kd;
                    kd = (k == 2 && s % 2 == 1) ? 2'd3 : 2'(k);
                    run_access(kd, 16'(16'hA000 + s * 64 + g * 8 + k), oo, cy, g[0],
                               4'(acc_idx), (k == 1) && (s % 4 == 0));
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule